// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog timer that software reaches over a small 32-bit register bus. When it is enabled, a first countdown phase runs and software must restart it at regular intervals with a kick. If the first phase runs out, the block raises a pre-timeout interrupt and moves into a second phase. Kicks are ignored in the second phase. When the second phase also runs out, the block raises a second interrupt and a one-cycle reset request. The reset request carries a reset-mode code that the reset distribution logic decodes.

Each phase is measured in prescaled ticks. The base tick is 2^`BASE_EXP` bus clocks, and a 2-bit prescale field multiplies it by 1, 2, 4 or 8. Each phase has its own 5-bit length field. Software uses the first phase as its service window and the second as a grace period for clean-up before the reset. Clearing the enable bit is the only way to stop a pending reset.

Top module: `wdog_two_phase`

## Requirements
- R1: After reset, the control register reads 0x00000001 (disabled, CPU reset mode) and the status register reads 0. `irq_phase1_o`, `irq_phase2_o` and `rst_req_o` are low, and `rst_mode_o` is 1.
- R2: The control register is at offset 0x8. Bit 31 is enable, bits 30:29 are prescale, bits 26:22 are the phase-1 length, bits 19:15 are the phase-2 length and bits 1:0 are the reset mode. All other bits read 0. The kick register at 0x0 reads 0.
- R3: One tick lasts 2^(`BASE_EXP`+prescale) bus clocks.
- R4: A phase-1 length of N gives a phase 1 of N+1 ticks, counted from the write that sets enable from 0 to 1. The phase-1 flag sets at the end of that time.
- R5: A phase-2 length of M gives a phase 2 of M+1 ticks, which starts where phase 1 ends. At its end the phase-2 flag sets and `rst_req_o` pulses high for exactly one cycle, both on the same edge.
- R6: Writing bit 31 = 1 at offset 0x0 during phase 1 restarts both the prescaler and phase 1.
- R7: A kick written during phase 2 has no effect on when the reset request occurs.
- R8: Writing enable = 0 stops the timer in either phase, and no reset request follows.
- R9: The status register is at offset 0x4: bit 31 is the phase-1 flag and bit 30 is the phase-2 flag. Writing 1 to a bit clears that flag. If a new event lands in the same cycle as the clear, the flag stays set. The interrupt outputs equal the flags.
- R10: `rst_mode_o` takes the reset mode at the moment phase 2 expires and holds it: 0 means full chip, 1 means CPU only and 2 means software. A mode of 3 is issued as 0.
- R11: After phase 2 has expired, the timer stays halted and issues no further events until enable is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_phase1_o | output | 1 | Pre-timeout interrupt level (phase-1 flag) |
| irq_phase2_o | output | 1 | Phase-2 interrupt level (phase-2 flag) |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_mode_o | output | 2 | Reset mode latched when phase 2 expired |

## Verification
The bench builds the block with `BASE_EXP` = 2, which gives a tick of only 4 clocks at prescale 0. With ticks this short, the exact cycle at which each phase ends can be checked for every prescale value, including both 1-tick phases and the longest 32-tick phases at prescale 3, all within a few thousand cycles. The short tick also makes it practical to place a kick or a flag clear on the exact edge where an expiry occurs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned MODE_W = 2;

  localparam logic [7:0] OFF_KICK = 8'h0;
  localparam logic [7:0] OFF_STAT = 8'h4;
  localparam logic [7:0] OFF_CTRL = 8'h8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef struct packed {
    logic              en;
    logic [PRE_W-1:0]  pre;
    logic [LEN_W-1:0]  len1;
    logic [LEN_W-1:0]  len2;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, pre: '0, len1: '0, len2: '0, mode: 2'd1};

  // mode 3 is not a defined reset kind; issue the full chip reset instead
  function automatic logic [MODE_W-1:0] map_mode(logic [MODE_W-1:0] m);
    return (m == 2'd3) ? 2'd0 : m;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ev1_i,
  input  logic              ev2_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o,
  output logic              flag1_o,
  output logic              flag2_o,
  output logic [31:0]       rdata_o
);
  ctrl_t ctrl_q;
  logic  flag1_q, flag2_q;
  logic  sel_kick, sel_stat, sel_ctrl;
  logic  clr1, clr2;

  assign sel_kick = (addr_i == ADDR_W'(OFF_KICK));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));
  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));

  assign start_o = wr_i && sel_ctrl && wdata_i[31] && !ctrl_q.en;
  assign stop_o  = wr_i && sel_ctrl && !wdata_i[31];
  assign kick_o  = wr_i && sel_kick && wdata_i[31];
  assign clr1    = wr_i && sel_stat && wdata_i[31];
  assign clr2    = wr_i && sel_stat && wdata_i[30];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_i && sel_ctrl) begin
      ctrl_q.en   <= wdata_i[31];
      ctrl_q.pre  <= wdata_i[30:29];
      ctrl_q.len1 <= wdata_i[26:22];
      ctrl_q.len2 <= wdata_i[19:15];
      ctrl_q.mode <= wdata_i[1:0];
    end
  end

  // set has priority over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      flag1_q <= ev1_i | (flag1_q & ~clr1);
      flag2_q <= ev2_i | (flag2_q & ~clr2);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)
      rdata_o = {ctrl_q.en, ctrl_q.pre, 2'b00, ctrl_q.len1, 2'b00, ctrl_q.len2,
                 13'd0, ctrl_q.mode};
    else if (sel_stat)
      rdata_o = {flag1_q, flag2_q, 30'd0};
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[28:27], wdata_i[21:20], wdata_i[14:2]};

  assign ctrl_o  = ctrl_q;
  assign flag1_o = flag1_q;
  assign flag2_o = flag2_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev1_i |=> flag1_q);
  a_r9_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr2 && !ev2_i) |=> !flag2_q);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int unsigned MAX_SHIFT = BASE_EXP + (1 << PRE_W) - 1;
  localparam int unsigned CNT_W     = MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;

  assign span   = (CNT_W+1)'(1) << (BASE_EXP + int'(pre_i));
  assign last   = CNT_W'(span - 1'b1);
  // >= keeps ticking sane when prescale shrinks mid-count
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i || !run_i || tick_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_phase_fsm.sv
module wdog_phase_fsm
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              kick_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  len1_i,
  input  logic [LEN_W-1:0]  len2_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              run_o,
  output logic              presc_clr_o,
  output logic              ev1_o,
  output logic              ev2_o,
  output logic              rst_req_o,
  output logic [MODE_W-1:0] rst_mode_o
);
  phase_e            state_q, state_d;
  logic [LEN_W-1:0]  ticks_q, ticks_d;
  logic [LEN_W-1:0]  len_cur;
  logic              expire;
  logic              rst_req_q;
  logic [MODE_W-1:0] rst_mode_q;

  assign len_cur = (state_q == PH_TWO) ? len2_i : len1_i;
  assign expire  = tick_i && (ticks_q >= len_cur);

  always_comb begin
    state_d = state_q;
    ticks_d = ticks_q;
    ev1_o   = 1'b0;
    ev2_o   = 1'b0;
    if (stop_i) begin
      state_d = PH_IDLE;
      ticks_d = '0;
    end else if (start_i) begin
      state_d = PH_ONE;
      ticks_d = '0;
    end else begin
      unique case (state_q)
        PH_ONE: begin
          if (kick_i) begin
            ticks_d = '0;
          end else if (expire) begin
            state_d = PH_TWO;
            ticks_d = '0;
            ev1_o   = 1'b1;
          end else if (tick_i) begin
            ticks_d = ticks_q + 1'b1;
          end
        end
        PH_TWO: begin
          if (expire) begin
            state_d = PH_DONE;
            ticks_d = '0;
            ev2_o   = 1'b1;
          end else if (tick_i) begin
            ticks_d = ticks_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PH_IDLE;
      ticks_q    <= '0;
      rst_req_q  <= 1'b0;
      rst_mode_q <= 2'd1;
    end else begin
      state_q   <= state_d;
      ticks_q   <= ticks_d;
      rst_req_q <= ev2_o;
      if (ev2_o) rst_mode_q <= map_mode(mode_i);
    end
  end

  assign run_o       = (state_q == PH_ONE) || (state_q == PH_TWO);
  assign presc_clr_o = start_i || ((state_q == PH_ONE) && kick_i);
  assign rst_req_o   = rst_req_q;
  assign rst_mode_o  = rst_mode_q;

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
  a_r7_kick_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_TWO && kick_i && !stop_i && !tick_i) |=>
      (state_q == PH_TWO && $stable(ticks_q)));
  a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == PH_IDLE && !rst_req_q));
  a_r11_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DONE && !stop_i) |=> (state_q == PH_DONE && !rst_req_q));
endmodule

// File: rtl/wdog_two_phase.sv
module wdog_two_phase
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 25,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_phase1_o,
  output logic              irq_phase2_o,
  output logic              rst_req_o,
  output logic [1:0]        rst_mode_o
);
  ctrl_t ctrl;
  logic  start, stop, kick, tick, run, presc_clr, ev1, ev2;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .ev1_i   (ev1),
    .ev2_i   (ev2),
    .ctrl_o  (ctrl),
    .start_o (start),
    .stop_o  (stop),
    .kick_o  (kick),
    .flag1_o (irq_phase1_o),
    .flag2_o (irq_phase2_o),
    .rdata_o (bus_rdata_o)
  );

  wdog_prescaler #(.BASE_EXP(BASE_EXP)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .clear_i (presc_clr),
    .pre_i   (ctrl.pre),
    .tick_o  (tick)
  );

  wdog_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .kick_i      (kick),
    .tick_i      (tick),
    .len1_i      (ctrl.len1),
    .len2_i      (ctrl.len2),
    .mode_i      (ctrl.mode),
    .run_o       (run),
    .presc_clr_o (presc_clr),
    .ev1_o       (ev1),
    .ev2_o       (ev2),
    .rst_req_o   (rst_req_o),
    .rst_mode_o  (rst_mode_o)
  );

  a_r5_rst_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> irq_phase2_o);
  a_r10_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_mode_o != 2'd3));
endmodule

// File: tb/wdog_two_phase_tb.sv
module wdog_two_phase_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 2;
  localparam int NVEC       = 6;
  // columns: prescale, len1, len2, mode, expected phase-1 end, expected reset, expected mode
  localparam int VEC [NVEC][7] = '{
    '{0,  0,  0, 0,    4,    8, 0},
    '{1,  3,  1, 1,   32,   48, 1},
    '{2,  2,  0, 2,   48,   64, 2},
    '{0, 31,  0, 2,  128,  132, 2},
    '{3, 31, 31, 3, 1024, 2048, 0},
    '{1,  0,  4, 1,    8,   48, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq1, irq2, rst_req;
  logic [1:0]  rst_mode;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_phase #(.BASE_EXP(BASE_EXP), .ADDR_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_phase1_o(irq1),
    .irq_phase2_o(irq2), .rst_req_o(rst_req), .rst_mode_o(rst_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(logic en, logic [1:0] pre, logic [4:0] l1,
                                          logic [4:0] l2, logic [1:0] md);
    return {en, pre, 2'b00, l1, 2'b00, l2, 13'd0, md};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h8, r); check("R1 ctrl reset", r, 32'h0000_0001);
    rd(4'h4, r); check("R1 status reset", r, 32'h0);
    check("R1 outputs", {29'd0, irq1, irq2, rst_req}, 32'h0);
    check("R1 rst_mode", {30'd0, rst_mode}, 32'd1);

    // R2 field layout, timer left disabled
    wr(4'h8, 32'h7FFF_FFFF);
    rd(4'h8, r); check("R2 ctrl layout", r, 32'h67CF_8003);
    rd(4'h0, r); check("R2 kick reads 0", r, 32'h0);
    wr(4'h8, 32'h0000_0001);

    // R3/R4/R5/R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(4'h8, 32'h0000_0001);
      wr(4'h4, 32'hC000_0000);
      wr(4'h8, mk_ctrl(1'b1, 2'(VEC[i][0]), 5'(VEC[i][1]), 5'(VEC[i][2]), 2'(VEC[i][3])));
      c = 0;
      while (!irq1 && c < 5000) begin @(negedge clk); c++; end
      check($sformatf("R3 R4 vec%0d phase1 end", i), c, VEC[i][4]);
      while (!rst_req && c < 10000) begin @(negedge clk); c++; end
      check($sformatf("R3 R5 vec%0d reset time", i), c, VEC[i][5]);
      check($sformatf("R5 vec%0d flag2 with reset", i), {31'd0, irq2}, 32'd1);
      check($sformatf("R10 vec%0d mode", i), {30'd0, rst_mode}, VEC[i][6]);
      @(negedge clk);
      check($sformatf("R5 vec%0d single pulse", i), {31'd0, rst_req}, 32'd0);
    end

    // R11 halted after expiry, no more events
    pulses = 0;
    repeat (100) begin @(negedge clk); if (rst_req) pulses++; end
    check("R11 no pulse after expiry", pulses, 0);
    // R9 clearing phase-2 flag only
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, r); check("R9 clear bit30 only", r, 32'h8000_0000);
    check("R9 irq levels", {30'd0, irq1, irq2}, 32'b10);
    wr(4'h4, 32'h8000_0000);
    repeat (100) @(negedge clk);
    rd(4'h4, r); check("R11 no new flags", r, 32'h0);

    // R6 kick restarts phase 1
    wr(4'h8, 32'h0000_0001);
    wr(4'h8, mk_ctrl(1'b1, 2'd0, 5'd3, 5'd0, 2'd1));
    repeat (9) @(negedge clk);
    check("R6 no flag before kick", {31'd0, irq1}, 32'd0);
    wr(4'h0, 32'h8000_0000);
    c = 0;
    while (!irq1 && c < 5000) begin @(negedge clk); c++; end
    check("R6 phase1 after kick", c, 16);

    // R7 kick during phase 2 ignored
    wr(4'h8, 32'h0000_0001);
    wr(4'h4, 32'hC000_0000);
    wr(4'h8, mk_ctrl(1'b1, 2'd0, 5'd0, 5'd3, 2'd2));
    c = 0;
    while (!irq1 && c < 5000) begin @(negedge clk); c++; end
    check("R7 phase1 end", c, 4);
    wr(4'h0, 32'h8000_0000); c++;
    while (!rst_req && c < 5000) begin @(negedge clk); c++; end
    check("R7 reset unchanged by kick", c, 20);

    // R9 clear colliding with new event: set wins
    wr(4'h8, 32'h0000_0001);
    wr(4'h4, 32'hC000_0000);
    wr(4'h8, mk_ctrl(1'b1, 2'd0, 5'd0, 5'd31, 2'd0));
    repeat (3) @(negedge clk);
    check("R9 flag clear before event", {31'd0, irq1}, 32'd0);
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, r); check("R9 set wins over clear", r, 32'h8000_0000);
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, r); check("R9 w1c clears", r, 32'h0);
    check("R9 irq1 low", {31'd0, irq1}, 32'd0);

    // R8 disable during phase 2 cancels reset
    wr(4'h8, 32'h0000_0001);
    wr(4'h4, 32'hC000_0000);
    wr(4'h8, mk_ctrl(1'b1, 2'd0, 5'd0, 5'd3, 2'd0));
    c = 0;
    while (!irq1 && c < 5000) begin @(negedge clk); c++; end
    check("R8 entered phase 2", c, 4);
    wr(4'h8, 32'h0000_0000);
    pulses = 0;
    repeat (100) begin @(negedge clk); if (rst_req) pulses++; end
    check("R8 no reset after disable", pulses, 0);
    check("R8 no phase2 flag", {31'd0, irq2}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule